// File: doc/BRIEF.md
# Multiprocessor Priority Interrupt Controller

This block collects a parameterized set of external interrupt request lines (16 by default) and hands each request to one of a small number of processors (2 by default). Every source carries its own vector, 4-bit priority, trigger mode, polarity, enable mask and a processor routing bitmask. Every processor has one interrupt line. It also has three registers: one read returns and claims the best pending vector, one write retires the most urgent interrupt it is handling, and a threshold register holds off requests of lower urgency.

Software reaches all state over a simple synchronous bus with separate read and write strobes. Read data is registered and appears the cycle after the read strobe. A read of a processor's claim register has a side effect: the selected source moves from pending to in service. A global word holds a self-clearing soft-reset bit and one stored legacy-mode flag. A read-only word reports the revision and the block's dimensions. A programmable vector is returned when a claim finds nothing eligible.

Top module: `mp_irq_ctrl`

## Requirements
- R1: After `rst`, or after a write of 1 to bit 0 of the global config word, every source reads masked with all other fields 0, destinations and thresholds are 0, the spurious vector is 0xFF, `irq_o` is low, and the config word reads back with bit 0 clear.
- R2: Address map: addr[7:6]=00 is global (addr[1:0]: 0 config, 1 feature, 2 spurious vector); 01 is source addr[5:1] (addr[0]: 0 config, 1 destination); 10 is processor addr[5:2] (addr[1:0]: 0 claim, 1 retire, 2 threshold). Source config bits: [7:0] vector, [11:8] priority, [16] polarity, [17] sense, [30] activity (read-only), [31] mask. The feature word reads {8'h00, NCPU-1, NSRC-1, 8'h02}.
- R3: A source whose mask bit is 1 never raises `irq_o` and is never claimed.
- R4: Sense 1 is level mode, with polarity 1 active-high and 0 active-low. Sense 0 is edge mode, with polarity 1 rising and 0 falling. An edge of the other direction is ignored. `irq_o` follows a level one clock after `irq_in` and an edge two clocks after it.
- R5: A source is offered only to processors whose bit is set in its destination word.
- R6: A claim read returns the vector of the highest-priority eligible source for that processor, with ties going to the lowest source index. That source becomes in service and is offered to no processor until retired.
- R7: A claim read that finds no eligible source returns the spurious vector in bits [7:0] and changes no state.
- R8: Any write to a processor's retire register clears the in-service source of highest priority on that processor, with ties going to the lowest index. The written data is ignored, and a write with nothing in service has no effect.
- R9: A source is eligible for a processor only if its priority is strictly greater than that processor's threshold, so priority 0 is never delivered.
- R10: An edge-mode pending latch clears on claim, so `irq_o` stays low after retire until a new edge. A level-mode source still asserted at retire becomes pending again at once.
- R11: Bit 1 of the global config word is a stored flag that reads back as written.
- R12: The activity bit reads 1 exactly while the source is pending (an edge latch, or an unmasked asserted level) or in service on any processor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 8 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| irq_in | input | NSRC | External request lines |
| irq_o | output | NCPU | Per-processor interrupt lines |

## Verification
The bench keeps a behavioural model of pending, ownership and thresholds, and compares `irq_o` every cycle and the read data after every read. The corner cases it targets are as follows. Two equal-priority sources routed to both processors test the lowest-index rule. A design that got this wrong would return vector 0x68 first. A retire on a processor holding sources of priority 9 and 4 must free the priority-9 one. A design that picked by index or by arrival would leave the wrong line re-pending. An edge source must stay quiet after retire, while a held level must come back at once. A wrong edge latch would show up as a phantom or a lost interrupt. Thresholds equal to the priority and sources of priority 0 must block delivery, and a claim then returns the programmed spurious vector. An off-by-one comparison would raise `irq_o` instead.

// File: rtl/mp_irq_pkg.sv
package mp_irq_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int VEC_W  = 8;
    localparam int PRI_W  = 4;

    localparam logic [7:0]       REVISION  = 8'h02;
    localparam logic [VEC_W-1:0] SPUR_INIT = 8'hFF;

    localparam int POS_PRI   = 8;
    localparam int POS_POL   = 16;
    localparam int POS_SENSE = 17;
    localparam int POS_ACT   = 30;
    localparam int POS_MASK  = 31;

    typedef enum logic [1:0] {RG_GLOBAL = 2'd0, RG_SOURCE = 2'd1, RG_CPU = 2'd2, RG_NONE = 2'd3} region_e;
    typedef enum logic [1:0] {GL_CONFIG = 2'd0, GL_FEATURE = 2'd1, GL_SPURIOUS = 2'd2, GL_RSVD = 2'd3} glob_e;
    typedef enum logic [1:0] {CP_CLAIM = 2'd0, CP_RETIRE = 2'd1, CP_THRESH = 2'd2, CP_RSVD = 2'd3} cpu_e;

    typedef struct packed {
        logic             mask;
        logic             sense;
        logic             pol;
        logic [PRI_W-1:0] pri;
        logic [VEC_W-1:0] vec;
    } src_cfg_t;

    localparam src_cfg_t CFG_INIT = '{mask: 1'b1, sense: 1'b0, pol: 1'b0, pri: '0, vec: '0};

    function automatic logic [DATA_W-1:0] cfg_to_word(src_cfg_t c, logic act);
        logic [DATA_W-1:0] w;
        w = '0;
        w[VEC_W-1:0]               = c.vec;
        w[POS_PRI +: PRI_W]        = c.pri;
        w[POS_POL]                 = c.pol;
        w[POS_SENSE]               = c.sense;
        w[POS_ACT]                 = act;
        w[POS_MASK]                = c.mask;
        return w;
    endfunction

    function automatic src_cfg_t word_to_cfg(logic [DATA_W-1:0] w);
        src_cfg_t c;
        c.vec   = w[VEC_W-1:0];
        c.pri   = w[POS_PRI +: PRI_W];
        c.pol   = w[POS_POL];
        c.sense = w[POS_SENSE];
        c.mask  = w[POS_MASK];
        return c;
    endfunction
endpackage

// File: rtl/mp_irq_src.sv
module mp_irq_src
    import mp_irq_pkg::*;
#(
    parameter int NCPU = 2
) (
    input  logic              clk,
    input  logic              srst,
    input  logic              irq_in,
    input  logic              cfg_we,
    input  logic              dest_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NCPU-1:0]   take,
    input  logic [NCPU-1:0]   retire,
    output src_cfg_t          cfg,
    output logic [NCPU-1:0]   dest,
    output logic              req,
    output logic              active,
    output logic [NCPU-1:0]   insvc
);
    logic samp, samp_d, edge_lat;
    logic lvl_on, edge_hit, pend;

    always_comb begin
        lvl_on   = cfg.pol ? samp : ~samp;
        edge_hit = cfg.pol ? (samp & ~samp_d) : (~samp & samp_d);
        pend     = cfg.sense ? (lvl_on & ~cfg.mask) : edge_lat;
        req      = pend & ~cfg.mask & ~(|insvc);
        active   = pend | (|insvc);
    end

    always_ff @(posedge clk) begin
        if (srst) begin
            samp     <= 1'b0;
            samp_d   <= 1'b0;
            edge_lat <= 1'b0;
            cfg      <= CFG_INIT;
            dest     <= '0;
            insvc    <= '0;
        end else begin
            samp   <= irq_in;
            samp_d <= samp;
            if (~cfg.sense & ~cfg.mask & edge_hit)
                edge_lat <= 1'b1;
            else if (|take)
                edge_lat <= 1'b0;
            if (cfg_we)
                cfg <= word_to_cfg(wdata);
            if (dest_we)
                dest <= wdata[NCPU-1:0];
            insvc <= (insvc & ~retire) | take;
        end
    end
endmodule

// File: rtl/mp_irq_pick.sv
module mp_irq_pick #(
    parameter int N  = 16,
    parameter int W  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]        cand,
    input  logic [N-1:0][W-1:0] pri,
    output logic                found,
    output logic [IW-1:0]       idx
);
    logic [W-1:0] best;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (!found || pri[i] > best)) begin
                found = 1'b1;
                idx   = IW'(i);
                best  = pri[i];
            end
        end
    end
endmodule

// File: rtl/mp_irq_ctrl.sv
module mp_irq_ctrl
    import mp_irq_pkg::*;
#(
    parameter int NSRC = 16,
    parameter int NCPU = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [NSRC-1:0]   irq_in,
    output logic [NCPU-1:0]   irq_o
);
    localparam int SIW = (NSRC > 1) ? $clog2(NSRC) : 1;
    localparam logic [DATA_W-1:0] FEATURE = {8'h00, 8'(NCPU-1), 8'(NSRC-1), REVISION};

    region_e    rg;
    logic [4:0] s_fld;
    logic [3:0] c_fld;
    logic [1:0] sub;
    logic       srst;

    assign rg    = region_e'(addr[7:6]);
    assign s_fld = addr[5:1];
    assign c_fld = addr[5:2];
    assign sub   = addr[1:0];
    assign srst  = rst | (wr_en && rg == RG_GLOBAL && sub == GL_CONFIG && wdata[0]);

    src_cfg_t                          cfg_a [NSRC];
    logic [NCPU-1:0]                   dest_a [NSRC];
    logic [NSRC-1:0]                   req_v, act_v, mask_v;
    logic [NSRC-1:0][PRI_W-1:0]        pri_v;
    logic [NSRC-1:0][VEC_W-1:0]        vec_v;
    logic [NSRC-1:0][NCPU-1:0]         insvc, take_m, retire_m;
    logic [NCPU-1:0]                   claim_rd, retire_wr, found_a, found_e;
    logic [NCPU-1:0][SIW-1:0]          idx_a, idx_e;
    logic [NCPU-1:0][PRI_W-1:0]        thresh;
    logic [VEC_W-1:0]                  spur;
    logic                              legacy_off;
    logic [DATA_W-1:0]                 rd_mux;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        mp_irq_src #(.NCPU(NCPU)) u_src (
            .clk    (clk),
            .srst   (srst),
            .irq_in (irq_in[s]),
            .cfg_we (wr_en && rg == RG_SOURCE && s_fld == 5'(s) && !addr[0]),
            .dest_we(wr_en && rg == RG_SOURCE && s_fld == 5'(s) && addr[0]),
            .wdata  (wdata),
            .take   (take_m[s]),
            .retire (retire_m[s]),
            .cfg    (cfg_a[s]),
            .dest   (dest_a[s]),
            .req    (req_v[s]),
            .active (act_v[s]),
            .insvc  (insvc[s])
        );
        assign pri_v[s]  = cfg_a[s].pri;
        assign vec_v[s]  = cfg_a[s].vec;
        assign mask_v[s] = cfg_a[s].mask;
    end

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        logic [NSRC-1:0] cand_a, cand_e;

        assign claim_rd[c]  = rd_en && rg == RG_CPU && c_fld == 4'(c) && sub == CP_CLAIM;
        assign retire_wr[c] = wr_en && rg == RG_CPU && c_fld == 4'(c) && sub == CP_RETIRE;

        for (genvar s = 0; s < NSRC; s++) begin : g_el
            assign cand_a[s] = req_v[s] && dest_a[s][c] && (pri_v[s] > thresh[c]) && (pri_v[s] != '0);
            assign cand_e[s] = insvc[s][c];
            assign take_m[s][c]   = claim_rd[c] && found_a[c] && idx_a[c] == SIW'(s);
            assign retire_m[s][c] = retire_wr[c] && found_e[c] && idx_e[c] == SIW'(s);
        end

        mp_irq_pick #(.N(NSRC), .W(PRI_W), .IW(SIW)) u_claim_pick (
            .cand(cand_a), .pri(pri_v), .found(found_a[c]), .idx(idx_a[c])
        );
        mp_irq_pick #(.N(NSRC), .W(PRI_W), .IW(SIW)) u_retire_pick (
            .cand(cand_e), .pri(pri_v), .found(found_e[c]), .idx(idx_e[c])
        );
    end

    assign irq_o = found_a;

    always_ff @(posedge clk) begin
        if (srst) begin
            spur       <= SPUR_INIT;
            legacy_off <= 1'b0;
            thresh     <= '0;
        end else if (wr_en) begin
            if (rg == RG_GLOBAL && sub == GL_CONFIG)
                legacy_off <= wdata[1];
            if (rg == RG_GLOBAL && sub == GL_SPURIOUS)
                spur <= wdata[VEC_W-1:0];
            for (int c = 0; c < NCPU; c++)
                if (rg == RG_CPU && c_fld == 4'(c) && sub == CP_THRESH)
                    thresh[c] <= wdata[PRI_W-1:0];
        end
    end

    always_comb begin
        rd_mux = '0;
        case (rg)
            RG_GLOBAL: begin
                case (sub)
                    GL_CONFIG:   rd_mux[1] = legacy_off;
                    GL_FEATURE:  rd_mux = FEATURE;
                    GL_SPURIOUS: rd_mux[VEC_W-1:0] = spur;
                    default:     rd_mux = '0;
                endcase
            end
            RG_SOURCE: begin
                for (int s = 0; s < NSRC; s++)
                    if (s_fld == 5'(s))
                        rd_mux = addr[0] ? DATA_W'(dest_a[s]) : cfg_to_word(cfg_a[s], act_v[s]);
            end
            RG_CPU: begin
                for (int c = 0; c < NCPU; c++) begin
                    if (c_fld == 4'(c)) begin
                        case (sub)
                            CP_CLAIM:  rd_mux[VEC_W-1:0] = found_a[c] ? vec_v[idx_a[c]] : spur;
                            CP_THRESH: rd_mux[PRI_W-1:0] = thresh[c];
                            default:   rd_mux = '0;
                        endcase
                    end
                end
            end
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (srst)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_mux;
    end
endmodule

module mp_irq_ctrl_chk #(
    parameter int NSRC = 16,
    parameter int NCPU = 2,
    parameter int VW   = 8
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      srst,
    input logic                      rd_en,
    input logic                      wr_en,
    input logic [7:0]                addr,
    input logic [VW-1:0]             rdata_vec,
    input logic [VW-1:0]             spur,
    input logic [NCPU-1:0]           irq_o,
    input logic [NSRC-1:0]           mask_v,
    input logic [NSRC-1:0][NCPU-1:0] insvc
);
    logic [NCPU-1:0][NSRC-1:0] col;
    logic [NSRC-1:0]           owned;

    always_comb begin
        for (int c = 0; c < NCPU; c++)
            for (int s = 0; s < NSRC; s++)
                col[c][s] = insvc[s][c];
        for (int s = 0; s < NSRC; s++)
            owned[s] = |insvc[s];
    end

    p_reset_masks_r1: assert property (@(posedge clk) disable iff (rst)
        srst |=> (&mask_v) && (insvc == '0));

    for (genvar s = 0; s < NSRC; s++) begin : g_s
        p_single_owner_r6: assert property (@(posedge clk) disable iff (rst)
            $onehot0(insvc[s]));
        p_masked_unclaimed_r3: assert property (@(posedge clk) disable iff (rst)
            (mask_v[s] && !owned[s] && !srst) |=> !owned[s]);
    end

    for (genvar c = 0; c < NCPU; c++) begin : g_c
        p_retire_one_r8: assert property (@(posedge clk) disable iff (rst)
            (wr_en && !rd_en && !srst && addr[7:6] == 2'd2 && addr[5:2] == 4'(c)
             && addr[1:0] == 2'd1 && (|col[c]))
            |=> ($countones(col[c]) + 1 == $past($countones(col[c]))));
        p_spurious_claim_r7: assert property (@(posedge clk) disable iff (rst)
            (rd_en && !srst && addr[7:6] == 2'd2 && addr[5:2] == 4'(c)
             && addr[1:0] == 2'd0 && !irq_o[c])
            |=> (rdata_vec == $past(spur)));
    end
endmodule

bind mp_irq_ctrl mp_irq_ctrl_chk #(.NSRC(NSRC), .NCPU(NCPU), .VW(mp_irq_pkg::VEC_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .srst     (srst),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .addr     (addr),
    .rdata_vec(rdata[mp_irq_pkg::VEC_W-1:0]),
    .spur     (spur),
    .irq_o    (irq_o),
    .mask_v   (mask_v),
    .insvc    (insvc)
);

// File: tb/test_mp_irq_ctrl.sv
module test_mp_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 16;
    localparam int NC = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [NS-1:0] irq_in = '0;
    logic [NC-1:0] irq_o;

    mp_irq_ctrl #(.NSRC(NS), .NCPU(NC)) i_mp_irq_ctrl (
        .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq_in(irq_in), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 0;
    bit    mon_on = 0;
    string cur_req = "R1";

    // behavioural reference state
    bit m_mask[NS], m_sense[NS], m_pol[NS], m_edge[NS], m_q[NS], m_qq[NS];
    int m_pri[NS], m_vec[NS], m_dest[NS], m_owner[NS];
    int m_thr[NC];
    int m_spur;
    bit m_legacy;
    bit m_rdflag = 0;
    logic [31:0] m_rd;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [31:0] mkcfg(int vec, int pri, bit pol, bit sense, bit mask);
        return 32'(vec) | (32'(pri) << 8) | (32'(pol) << 16) | (32'(sense) << 17) | (32'(mask) << 31);
    endfunction

    function automatic bit pend_of(int s);
        bit lv;
        lv = m_pol[s] ? m_q[s] : !m_q[s];
        return m_sense[s] ? (lv && !m_mask[s]) : m_edge[s];
    endfunction

    function automatic int best_for(int c);
        int b;
        b = -1;
        for (int s = 0; s < NS; s++)
            if (!m_mask[s] && pend_of(s) && m_owner[s] < 0 && m_dest[s][c]
                && m_pri[s] > m_thr[c] && m_pri[s] != 0 && (b < 0 || m_pri[s] > m_pri[b]))
                b = s;
        return b;
    endfunction

    function automatic int best_owned(int c);
        int b;
        b = -1;
        for (int s = 0; s < NS; s++)
            if (m_owner[s] == c && (b < 0 || m_pri[s] > m_pri[b]))
                b = s;
        return b;
    endfunction

    task automatic model_reset();
        for (int s = 0; s < NS; s++) begin
            m_mask[s] = 1; m_sense[s] = 0; m_pol[s] = 0; m_edge[s] = 0;
            m_q[s] = 0; m_qq[s] = 0; m_pri[s] = 0; m_vec[s] = 0;
            m_dest[s] = 0; m_owner[s] = -1;
        end
        for (int c = 0; c < NC; c++) m_thr[c] = 0;
        m_spur = 'hFF;
        m_legacy = 0;
    endtask

    always @(posedge clk) begin
        int tk_s, tk_c, rt_s, s, c, r;
        bit hit, act;
        logic [31:0] v;
        tk_s = -1; tk_c = -1; rt_s = -1;
        m_rdflag = 0;
        if (rst || (wr_en && addr == 8'h00 && wdata[0])) begin
            model_reset();
        end else begin
            s = int'(addr[5:1]); c = int'(addr[5:2]); r = int'(addr[1:0]);
            if (rd_en) begin
                v = '0;
                case (addr[7:6])
                    2'd0: begin
                        if (r == 0) v = 32'(m_legacy) << 1;
                        else if (r == 1) v = {8'h00, 8'(NC-1), 8'(NS-1), 8'h02};
                        else if (r == 2) v = 32'(m_spur);
                    end
                    2'd1: begin
                        act = pend_of(s) || m_owner[s] >= 0;
                        v = addr[0] ? 32'(m_dest[s]) : (mkcfg(m_vec[s], m_pri[s], m_pol[s], m_sense[s], m_mask[s]) | (32'(act) << 30));
                    end
                    2'd2: begin
                        if (r == 0) begin
                            tk_s = best_for(c);
                            if (tk_s >= 0) begin tk_c = c; v = 32'(m_vec[tk_s]); end
                            else v = 32'(m_spur);
                        end else if (r == 2) v = 32'(m_thr[c]);
                    end
                    default: v = '0;
                endcase
                m_rd = v;
                m_rdflag = 1;
            end
            if (wr_en && addr[7:6] == 2'd2 && r == 1) rt_s = best_owned(c);
            for (int k = 0; k < NS; k++) begin
                hit = m_pol[k] ? (m_q[k] && !m_qq[k]) : (!m_q[k] && m_qq[k]);
                if (!m_sense[k] && !m_mask[k] && hit) m_edge[k] = 1;
                else if (tk_s == k) m_edge[k] = 0;
            end
            if (tk_s >= 0) m_owner[tk_s] = tk_c;
            if (rt_s >= 0) m_owner[rt_s] = -1;
            if (wr_en) begin
                if (addr[7:6] == 2'd0 && r == 0) m_legacy = wdata[1];
                if (addr[7:6] == 2'd0 && r == 2) m_spur = int'(wdata[7:0]);
                if (addr[7:6] == 2'd1 && !addr[0]) begin
                    m_vec[s] = int'(wdata[7:0]); m_pri[s] = int'(wdata[11:8]);
                    m_pol[s] = wdata[16]; m_sense[s] = wdata[17]; m_mask[s] = wdata[31];
                end
                if (addr[7:6] == 2'd1 && addr[0]) m_dest[s] = int'(wdata[NC-1:0]);
                if (addr[7:6] == 2'd2 && r == 2) m_thr[c] = int'(wdata[3:0]);
            end
            for (int k = 0; k < NS; k++) begin
                m_qq[k] = m_q[k];
                m_q[k] = irq_in[k];
            end
        end
    end

    // per-clock comparison against the reference
    always @(negedge clk) begin
        logic [NC-1:0] e;
        if (mon_on && !done) begin
            for (int c = 0; c < NC; c++) e[c] = (best_for(c) >= 0);
            chk({cur_req, " model irq_o"}, 32'(irq_o), 32'(e));
            if (m_rdflag) chk({cur_req, " model rdata"}, rdata, m_rd);
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1; addr = a; wdata = d;
        @(posedge clk); @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        rd_en = 1; addr = a;
        @(posedge clk); @(negedge clk);
        d = rdata; rd_en = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] a_cfg(int s);  return 8'h40 | 8'(s << 1); endfunction
    function automatic logic [7:0] a_dst(int s);  return 8'h41 | 8'(s << 1); endfunction
    function automatic logic [7:0] a_cpu(int c, int r); return 8'h80 | 8'(c << 2) | 8'(r); endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0; mon_on = 1;

        cur_req = "R1";
        rd(a_cfg(0), d);      chk("R1 src0 cfg", d, 32'h8000_0000);
        rd(8'h02, d);         chk("R1 spurious", d, 32'h0000_00FF);
        rd(a_dst(3), d);      chk("R1 dest", d, 0);
        rd(a_cpu(1, 2), d);   chk("R1 threshold", d, 0);
        chk("R1 irq_o", 32'(irq_o), 0);

        cur_req = "R2";
        rd(8'h01, d);         chk("R2 feature", d, 32'h0001_0F02);

        cur_req = "R3";
        wr(a_cfg(3), mkcfg('h23, 5, 1, 1, 1));
        wr(a_dst(3), 1);
        irq_in[3] = 1;
        idle(3);
        chk("R3 masked irq_o", 32'(irq_o), 0);
        rd(a_cfg(3), d);      chk("R3 masked cfg", d, 32'h8003_0523);
        wr(a_cfg(3), mkcfg('h23, 5, 1, 1, 0));
        chk("R3 unmasked irq_o", 32'(irq_o), 32'b01);
        chk("R5 cpu1 not routed", 32'(irq_o[1]), 0);

        cur_req = "R12";
        rd(a_cfg(3), d);      chk("R12 activity pending", d, 32'h4003_0523);

        cur_req = "R6";
        rd(a_cpu(0, 0), d);   chk("R6 claim vector", d, 32'h23);
        chk("R6 irq_o after claim", 32'(irq_o), 0);
        rd(a_cfg(3), d);      chk("R12 activity in service", d, 32'h4003_0523);

        cur_req = "R10";
        wr(a_cpu(0, 1), 32'hDEAD_BEEF);
        chk("R10 level re-pends", 32'(irq_o), 32'b01);
        rd(a_cpu(0, 0), d);   chk("R10 reclaim", d, 32'h23);
        irq_in[3] = 0;
        wr(a_cpu(0, 1), 0);
        idle(1);
        chk("R8 retired irq_o", 32'(irq_o), 0);
        rd(a_cfg(3), d);      chk("R12 activity idle", d, 32'h0003_0523);

        cur_req = "R7";
        rd(a_cpu(0, 0), d);   chk("R7 default spurious", d, 32'hFF);
        wr(8'h02, 32'h5A);
        rd(a_cpu(1, 0), d);   chk("R7 programmed spurious", d, 32'h5A);

        cur_req = "R4";
        wr(a_cfg(5), mkcfg('h45, 7, 0, 0, 0));
        wr(a_dst(5), 2);
        irq_in[5] = 1;
        idle(3);
        chk("R4 rising ignored", 32'(irq_o), 0);
        irq_in[5] = 0;
        idle(3);
        chk("R4 falling edge", 32'(irq_o), 32'b10);
        rd(a_cpu(1, 0), d);   chk("R4 edge claim", d, 32'h45);
        wr(a_cpu(1, 1), 0);
        idle(2);
        chk("R10 edge stays clear", 32'(irq_o), 0);
        wr(a_cfg(6), mkcfg('h56, 3, 0, 1, 0));
        wr(a_dst(6), 1);
        chk("R4 active-low level", 32'(irq_o), 32'b01);
        irq_in[6] = 1;
        idle(2);
        chk("R4 active-low released", 32'(irq_o), 0);
        wr(a_cfg(6), mkcfg('h56, 3, 0, 1, 1));

        cur_req = "R6";
        wr(a_cfg(7), mkcfg('h67, 9, 1, 1, 0)); wr(a_dst(7), 3);
        wr(a_cfg(8), mkcfg('h68, 9, 1, 1, 0)); wr(a_dst(8), 3);
        wr(a_cfg(2), mkcfg('h22, 4, 1, 1, 0)); wr(a_dst(2), 1);
        irq_in[7] = 1; irq_in[8] = 1; irq_in[2] = 1;
        idle(2);
        rd(a_cpu(0, 0), d);   chk("R6 tie lowest index", d, 32'h67);
        rd(a_cpu(0, 0), d);   chk("R6 second of tie", d, 32'h68);
        cur_req = "R5";
        rd(a_cpu(1, 0), d);   chk("R5 nothing routed to cpu1", d, 32'h5A);
        chk("R5 cpu0 still requests", 32'(irq_o), 32'b01);
        cur_req = "R6";
        rd(a_cpu(0, 0), d);   chk("R6 lower priority last", d, 32'h22);
        chk("R6 all owned", 32'(irq_o), 0);
        cur_req = "R8";
        wr(a_cpu(0, 1), 0);
        chk("R8 highest retired re-pends", 32'(irq_o), 32'b11);
        rd(a_cpu(1, 0), d);   chk("R8 retired source was 7", d, 32'h67);
        irq_in[7] = 0; irq_in[8] = 0; irq_in[2] = 0;
        idle(2);
        wr(a_cpu(0, 1), 0);
        wr(a_cpu(0, 1), 0);
        wr(a_cpu(1, 1), 0);
        rd(a_cfg(2), d);      chk("R8 all retired", d, 32'h0003_0422);
        wr(a_cpu(0, 1), 32'hFFFF_FFFF);
        chk("R8 empty retire no effect", 32'(irq_o), 0);

        cur_req = "R9";
        irq_in[3] = 1;
        idle(2);
        chk("R9 below threshold 0", 32'(irq_o), 32'b01);
        wr(a_cpu(0, 2), 5);
        chk("R9 equal blocks", 32'(irq_o), 0);
        wr(a_cpu(0, 2), 4);
        chk("R9 strictly above", 32'(irq_o), 32'b01);
        rd(a_cpu(0, 2), d);   chk("R9 threshold readback", d, 4);
        wr(a_cpu(0, 2), 0);
        wr(a_cfg(3), mkcfg('h23, 0, 1, 1, 0));
        chk("R9 priority zero", 32'(irq_o), 0);
        rd(a_cpu(0, 0), d);   chk("R9 priority zero claim", d, 32'h5A);

        cur_req = "R11";
        wr(8'h00, 32'h2);
        rd(8'h00, d);         chk("R11 legacy flag", d, 32'h2);

        cur_req = "R1";
        wr(a_cfg(3), mkcfg('h23, 5, 1, 1, 0));
        chk("R1 pre soft reset", 32'(irq_o), 32'b01);
        wr(8'h00, 32'h1);
        chk("R1 soft reset irq_o", 32'(irq_o), 0);
        rd(8'h00, d);         chk("R1 config self-clears", d, 0);
        rd(a_cfg(3), d);      chk("R1 soft reset cfg", d, 32'h8000_0000);
        rd(8'h02, d);         chk("R1 soft reset spurious", d, 32'hFF);
        irq_in = '0;
        idle(2);
        finish_run();
    end
endmodule